// File: doc/BRIEF.md
# Shared Interrupt Request Combiner

This block merges three event sources (a periodic tick, an alarm match and an end-of-update notice) onto a single active-low request line shared with other devices. Every source owns a sticky pending flag that is set by a one-clock pulse and stays set until software reads the status word or the block is reset. Each source also has an enable bit. The request line is pulled low while at least one pending flag has its enable bit set.

Software services the request by reading the status word. That read returns the three flags and a summary bit, clears all flags in the same clock, and so releases the line. The line is open-drain: it is either driven low or left at high impedance, so an external pull-up and other open-drain devices can share it. An event that arrives in the same cycle as the read is not lost. It stays pending for the next read.

Top module: `irq_combiner`

## Requirements
- R1: A one-clock pulse on a source's event input sets that source's pending flag at the next clock edge, and the flag stays set until a status read or reset, whether or not the source is enabled.
- R2: `irq_n` is driven to 0 while any pending flag has its enable bit set, and is high impedance otherwise. A pending flag whose enable bit is 0 never drives the line.
- R3: A status read (`stat_rd` high for one cycle) loads `stat_rdata` at that clock edge and clears every pending flag that had no new event in that cycle. The request line is released from the following cycle unless a new event re-arms it.
- R4: An event that arrives in the same cycle as a status read is absent from the data that read returns, and is reported by the next read.
- R5: Writing the enable register (`en_we` with `en_wdata`) changes the request line from the next clock edge, including for flags that are already pending.
- R6: Synchronous reset clears all pending flags, all enable bits and `stat_rdata`, and leaves `irq_n` at high impedance.
- R7: Status word layout: bit 0 = periodic flag, bit 1 = alarm flag, bit 2 = update-ended flag, and bit 3 = summary. The summary is the OR of (flag AND enable) over the three sources at the moment of the read. Enable bits use the same bit positions 0 to 2.
- R8: `stat_rdata` holds its value in every cycle without a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | One-clock periodic event pulse |
| evt_alarm | input | 1 | One-clock alarm event pulse |
| evt_update | input | 1 | One-clock update-ended event pulse |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | New enable bits (bit0 periodic, bit1 alarm, bit2 update) |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_rdata | output | 4 | Captured status word: summary in bit 3, flags in bits 2..0 |
| irq_n | output | 1 | Open-drain active-low request: 0 or high impedance |

## Verification
All of the block's state changes at one clock edge after the stimulus. An event pulse, an enable write or a status read presented in cycle N is reflected in the flags, in `stat_rdata` and on the request line right after the rising edge that ends cycle N. The bench drives its inputs on the falling edge and advances a behavioural reference model at the rising edge. It compares both outputs on the following falling edge, so every check samples one full register stage after the stimulus. The request line is read through a pulled-up net, so a released line reads as 1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_N        = 3;
    localparam int SRC_PERIODIC = 0;
    localparam int SRC_ALARM    = 1;
    localparam int SRC_UPDATE   = 2;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic     summary;
        src_vec_t flags;
    } stat_word_t;

    localparam int STAT_W = $bits(stat_word_t);

    // True when any pending source is also enabled
    function automatic logic any_armed(src_vec_t flags, src_vec_t en);
        return |(flags & en);
    endfunction

    function automatic stat_word_t make_status(src_vec_t flags, src_vec_t en);
        stat_word_t w;
        w.summary = any_armed(flags, en);
        w.flags   = flags;
        return w;
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  logic     clr,
    output src_vec_t flags
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (evt[i]) flags[i] <= 1'b1;   // new event wins over a clear
            else if (clr)    flags[i] <= 1'b0;
        end

        p_evt_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flags[i]);
        p_flag_sticky_r1: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr) |=> flags[i]);
        p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  src_vec_t wdata,
    output src_vec_t en
);
    always_ff @(posedge clk) begin
        if (rst)     en <= '0;
        else if (we) en <= wdata;
    end

    p_en_load_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (en == $past(wdata)));
    p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(en));
endmodule

// File: rtl/irqc_stat_reg.sv
module irqc_stat_reg
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd,
    input  src_vec_t   flags,
    input  src_vec_t   en,
    output stat_word_t word
);
    always_ff @(posedge clk) begin
        if (rst)     word <= '0;
        else if (rd) word <= make_status(flags, en);
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(word));
    p_capture_flags_r4: assert property (@(posedge clk) disable iff (rst)
        rd |=> (word.flags == $past(flags)));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_we,
    input  logic [SRC_N-1:0]  en_wdata,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_n
);
    src_vec_t   evt_vec;
    src_vec_t   flags;
    src_vec_t   en;
    stat_word_t word;
    logic       pull_low;

    always_comb begin
        evt_vec               = '0;
        evt_vec[SRC_PERIODIC] = evt_periodic;
        evt_vec[SRC_ALARM]    = evt_alarm;
        evt_vec[SRC_UPDATE]   = evt_update;
    end

    irqc_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_vec),
        .clr   (stat_rd),
        .flags (flags)
    );

    irqc_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (en_we),
        .wdata (en_wdata),
        .en    (en)
    );

    irqc_stat_reg u_stat (
        .clk   (clk),
        .rst   (rst),
        .rd    (stat_rd),
        .flags (flags),
        .en    (en),
        .word  (word)
    );

    assign stat_rdata = word;
    assign pull_low   = any_armed(flags, en);
    assign irq_n      = pull_low ? 1'b0 : 1'bz;

    p_release_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && (evt_vec == '0)) |=> !pull_low);
    p_summary_r7: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (word.summary == $past(pull_low)));
    p_event_armed_r2: assert property (@(posedge clk) disable iff (rst)
        (|(evt_vec & en) && !en_we) |=> pull_low);
    p_reset_idle_r6: assert property (@(posedge clk)
        rst |=> (!pull_low && word == '0));
endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
    logic       clk = 1'b0;
    logic       rst;
    logic       evt_periodic, evt_alarm, evt_update;
    logic       en_we;
    logic [2:0] en_wdata;
    logic       stat_rd;
    logic [3:0] stat_rdata;
    tri1        irq_line;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    logic [2:0] m_flags, m_en;
    logic [3:0] m_rdata;

    always #5 clk = ~clk;

    irq_combiner dut (
        .clk          (clk),
        .rst          (rst),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .en_we        (en_we),
        .en_wdata     (en_wdata),
        .stat_rd      (stat_rd),
        .stat_rdata   (stat_rdata),
        .irq_n        (irq_line)
    );

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic exp_line;
        exp_line = (|(m_flags & m_en)) ? 1'b0 : 1'b1;
        check({tag, " irq"}, {3'b000, irq_line}, {3'b000, exp_line});
        check({tag, " rdata"}, stat_rdata, m_rdata);
    endtask

    // one cycle: drive after falling edge, model at rising edge, check at next falling edge
    task automatic cyc(input logic [2:0] e, input logic we, input logic [2:0] wd,
                       input logic rd, input string tag);
        evt_periodic = e[0]; evt_alarm = e[1]; evt_update = e[2];
        en_we = we; en_wdata = wd; stat_rd = rd;
        @(posedge clk);
        if (rst) begin
            m_flags = '0; m_en = '0; m_rdata = '0;
        end else begin
            if (rd) m_rdata = {|(m_flags & m_en), m_flags};
            m_flags = (rd ? 3'b000 : m_flags) | e;
            if (we) m_en = wd;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        m_flags = '0; m_en = '0; m_rdata = '0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(3'b111, 1'b1, 3'b111, 1'b1, "R6");
        rst = 1'b0;
        cyc(3'b000, 1'b0, 3'b000, 1'b0, "R6");
        check("R6 rdata after reset", stat_rdata, 4'b0000);

        // R1 / R2: masked alarm event sets flag but leaves the line released
        cyc(3'b010, 1'b0, 3'b000, 1'b0, "R1");
        cyc(3'b000, 1'b0, 3'b000, 1'b0, "R2");
        check("R2 masked line", {3'b000, irq_line}, 4'b0001);
        cyc(3'b000, 1'b0, 3'b000, 1'b1, "R1");
        check("R1 flag read", stat_rdata, 4'b0010);

        // R5: enable a pending periodic flag
        cyc(3'b001, 1'b0, 3'b000, 1'b0, "R1");
        cyc(3'b000, 1'b1, 3'b001, 1'b0, "R5");
        check("R5 line low after enable", {3'b000, irq_line}, 4'b0000);
        cyc(3'b000, 1'b1, 3'b000, 1'b0, "R5");
        check("R5 line released after disable", {3'b000, irq_line}, 4'b0001);
        cyc(3'b000, 1'b1, 3'b111, 1'b0, "R5");

        // R3 / R7: read clears and reports summary
        cyc(3'b000, 1'b0, 3'b000, 1'b1, "R3");
        check("R7 summary word", stat_rdata, 4'b1001);
        check("R3 released", {3'b000, irq_line}, 4'b0001);

        // R8: rdata holds without reads
        for (int i = 0; i < 4; i++) cyc(3'b100, 1'b0, 3'b000, 1'b0, "R8");
        check("R8 hold", stat_rdata, 4'b1001);

        // R4: event coinciding with read
        cyc(3'b001, 1'b0, 3'b000, 1'b1, "R4");
        check("R4 first read", stat_rdata, 4'b1100);
        check("R4 still pending", {3'b000, irq_line}, 4'b0000);
        cyc(3'b000, 1'b0, 3'b000, 1'b1, "R4");
        check("R4 second read", stat_rdata, 4'b1001);

        // R7: summary 0 when only masked flags pending
        cyc(3'b000, 1'b1, 3'b010, 1'b0, "R7");
        cyc(3'b101, 1'b0, 3'b000, 1'b0, "R7");
        cyc(3'b000, 1'b0, 3'b000, 1'b1, "R7");
        check("R7 masked summary", stat_rdata, 4'b0101);

        // R6: reset while a flag is armed
        cyc(3'b010, 1'b0, 3'b000, 1'b0, "R6");
        rst = 1'b1;
        cyc(3'b000, 1'b0, 3'b000, 1'b0, "R6");
        rst = 1'b0;
        check("R6 mid reset line", {3'b000, irq_line}, 4'b0001);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [2:0] e;
            logic [2:0] wd;
            logic we, rd;
            e  = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            wd = 3'($urandom_range(0, 7));
            we = ($urandom_range(0, 7) == 0);
            rd = ($urandom_range(0, 4) == 0);
            cyc(e, we, wd, rd, "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule